// File: doc/BRIEF.md
# Early-Terminating Long Multiplier

This block forms the 64-bit product of two 32-bit operands, as signed or as unsigned values. It can also add a 64-bit addend to that product. The multiplier operand is consumed one 8-bit digit per cycle, so the run time depends on the data. Stepping stops as soon as the multiplier bits not yet consumed carry no further information. In signed mode, the last digit consumed is weighted as a signed value, so the sum always equals the exact two's-complement product.

A caller raises `start` for one cycle while the block is idle. In that cycle it presents the operands, the mode flags and the addend. `busy` stays high while the job runs. `done` pulses once, in the same cycle that `result` takes the new value. The same inputs always take the same number of cycles, so the latency is predictable from the operand values alone.

Top module: `eml_longmul`

## Requirements
- R1: With `signed_mode`=0 and `accum_mode`=0, `result` equals the unsigned 64-bit product of `mcand` and `mplier` in the cycle that `done` is high.
- R2: With `signed_mode`=1 and `accum_mode`=0, `result` equals the two's-complement 64-bit product of `mcand` and `mplier` when `done` is high.
- R3: With `accum_mode`=1, `result` equals that product plus `addend`, taken modulo 2^64.
- R4: Let `start` be sampled at rising edge s while idle. For a plain multiply, `done` is high after edge s+N, where N = 1 + k. k is the smallest value in {2,3,4} for which the check below holds:
  - unsigned mode: `mplier[31:8k]` is all zeros (always true for k=4);
  - signed mode: `mplier[31:8k-1]` are all equal.
- R5: If either operand is zero, a plain multiply takes N = 3.
- R6: With `accum_mode`=1, N grows by 1 more cycle when `addend[63:32]` is zero and by 2 otherwise, giving 4 to 7 in total.
- R7: `busy` is high from the edge that samples `start` until `done` rises. `busy` is low while `done` is high, and `done` lasts exactly one cycle.
- R8: A `start` raised while `busy` is high is ignored. The running job keeps its result and latency, and no extra `done` follows.
- R9: After synchronous reset, `busy`=0, `done`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a job; sampled only while idle |
| signed_mode | input | 1 | 1: operands are two's complement |
| accum_mode | input | 1 | 1: add `addend` to the product |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier; its digits set the step count |
| addend | input | 64 | Value added in accumulate mode |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Product or product-plus-addend, held until the next completion |

## Verification
The bench builds the block with its default parameters: 32-bit operands, 8-bit digits and a floor of two digit steps. With these values each digit boundary of the multiplier lies at a fixed bit position. Operands can therefore be placed to reach every step count from two to four, in both signed and unsigned modes, and every total latency from 3 to 7 once the two accumulate cases are added. Directed operands sit on each termination boundary, including the signed boundary one bit below each digit edge. A seeded pseudo-random sweep covers mixed signs and carries from the low half into the high half.

// File: rtl/eml_pkg.sv
package eml_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STEP,
        ST_ACC_LO,
        ST_ACC_HI
    } eml_state_e;

    typedef struct packed {
        logic sgn;
        logic accum;
    } eml_mode_t;

    function automatic logic uniform_bits(input logic [63:0] v, input int unsigned n);
        logic [63:0] mask;
        logic [63:0] sel;
        mask = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
        sel  = v & mask;
        return (sel == 64'd0) || (sel == mask);
    endfunction

endpackage

// File: rtl/eml_span.sv
module eml_span #(
    parameter int OP_W      = 32,
    parameter int DIG_W     = 8,
    parameter int MIN_STEPS = 2,
    localparam int NDIG     = OP_W / DIG_W,
    localparam int CNT_W    = $clog2(NDIG + 1)
) (
    input  logic [OP_W-1:0]  mcand,
    input  logic [OP_W-1:0]  mplier,
    input  logic             sgn,
    output logic [CNT_W-1:0] steps
);

    logic [OP_W-1:0] rest;

    always_comb begin
        steps = CNT_W'(NDIG);
        rest  = '0;
        for (int k = NDIG; k >= MIN_STEPS; k--) begin
            if (sgn)
                rest = $unsigned($signed(mplier) >>> (k * DIG_W - 1));
            else
                rest = mplier >> (k * DIG_W);
            if ((rest == '0) || (&rest))
                steps = CNT_W'(k);
        end
        if ((mcand == '0) || (mplier == '0))
            steps = CNT_W'(MIN_STEPS);
    end

    always_comb begin
        a_r4_steps_range: assert (steps >= CNT_W'(MIN_STEPS) && steps <= CNT_W'(NDIG));
    end

endmodule

// File: rtl/eml_pp.sv
module eml_pp #(
    parameter int OP_W   = 32,
    parameter int DIG_W  = 8,
    localparam int NDIG  = OP_W / DIG_W,
    localparam int CNT_W = $clog2(NDIG + 1),
    localparam int ACC_W = 2 * OP_W,
    localparam int PPW   = OP_W + DIG_W + 2
) (
    input  logic [OP_W-1:0]  mcand,
    input  logic [OP_W-1:0]  mplier,
    input  logic [CNT_W-1:0] idx,
    input  logic             sgn,
    input  logic             last,
    output logic [ACC_W-1:0] pp
);

    logic [DIG_W-1:0]       digit;
    logic signed [PPW-1:0]  a_w;
    logic signed [PPW-1:0]  d_w;
    logic signed [PPW-1:0]  prod;
    logic                   a_top;
    logic                   d_top;

    always_comb begin
        digit = mplier[idx * DIG_W +: DIG_W];
        a_top = sgn & mcand[OP_W-1];
        d_top = sgn & last & digit[DIG_W-1];
        a_w   = $signed({{(PPW - OP_W){a_top}}, mcand});
        d_w   = $signed({{(PPW - DIG_W){d_top}}, digit});
        prod  = a_w * d_w;
        pp    = {{(ACC_W - PPW){prod[PPW-1]}}, prod} << (idx * DIG_W);
    end

endmodule

// File: rtl/eml_adder.sv
module eml_adder #(
    parameter int HALF_W = 32
) (
    input  logic [HALF_W-1:0] x,
    input  logic [HALF_W-1:0] y,
    input  logic              cin,
    output logic [HALF_W-1:0] sum,
    output logic              cout
);

    always_comb begin
        {cout, sum} = {1'b0, x} + {1'b0, y} + {{HALF_W{1'b0}}, cin};
    end

endmodule

// File: rtl/eml_longmul.sv
module eml_longmul
    import eml_pkg::*;
#(
    parameter int OP_W      = 32,
    parameter int DIG_W     = 8,
    parameter int MIN_STEPS = 2,
    localparam int NDIG     = OP_W / DIG_W,
    localparam int CNT_W    = $clog2(NDIG + 1),
    localparam int ACC_W    = 2 * OP_W,
    localparam int RUN_W    = $clog2(NDIG + 4)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             signed_mode,
    input  logic             accum_mode,
    input  logic [OP_W-1:0]  mcand,
    input  logic [OP_W-1:0]  mplier,
    input  logic [ACC_W-1:0] addend,
    output logic             busy,
    output logic             done,
    output logic [ACC_W-1:0] result
);

    eml_state_e        state_q;
    eml_mode_t         mode_q;
    logic [OP_W-1:0]   a_q, b_q;
    logic [ACC_W-1:0]  acc_q, sum_q, result_q;
    logic [CNT_W-1:0]  nsteps_q, idx_q, span_steps;
    logic              carry_q, done_q, last_step, acc_hi_zero;
    logic [RUN_W-1:0]  run_cnt;
    logic [ACC_W-1:0]  pp, sum_next;
    logic [OP_W-1:0]   add_x, add_y, add_sum, hi_inc;
    logic              add_cin, add_cout;

    eml_span #(.OP_W(OP_W), .DIG_W(DIG_W), .MIN_STEPS(MIN_STEPS)) u_span (
        .mcand (a_q),
        .mplier(b_q),
        .sgn   (mode_q.sgn),
        .steps (span_steps)
    );

    eml_pp #(.OP_W(OP_W), .DIG_W(DIG_W)) u_pp (
        .mcand (a_q),
        .mplier(b_q),
        .idx   (idx_q),
        .sgn   (mode_q.sgn),
        .last  (last_step),
        .pp    (pp)
    );

    eml_adder #(.HALF_W(OP_W)) u_add (
        .x   (add_x),
        .y   (add_y),
        .cin (add_cin),
        .sum (add_sum),
        .cout(add_cout)
    );

    always_comb begin
        last_step   = (idx_q == nsteps_q - CNT_W'(1));
        sum_next    = sum_q + pp;
        acc_hi_zero = (acc_q[ACC_W-1:OP_W] == '0);
        if (state_q == ST_ACC_HI) begin
            add_x   = sum_q[ACC_W-1:OP_W];
            add_y   = acc_q[ACC_W-1:OP_W];
            add_cin = carry_q;
        end else begin
            add_x   = sum_q[OP_W-1:0];
            add_y   = acc_q[OP_W-1:0];
            add_cin = 1'b0;
        end
        hi_inc = sum_q[ACC_W-1:OP_W] + OP_W'(add_cout);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= '0;
            a_q      <= '0;
            b_q      <= '0;
            acc_q    <= '0;
            sum_q    <= '0;
            result_q <= '0;
            nsteps_q <= CNT_W'(MIN_STEPS);
            idx_q    <= '0;
            carry_q  <= 1'b0;
            done_q   <= 1'b0;
            run_cnt  <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q != ST_IDLE)
                run_cnt <= run_cnt + RUN_W'(1);
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_q          <= mcand;
                        b_q          <= mplier;
                        acc_q        <= addend;
                        mode_q.sgn   <= signed_mode;
                        mode_q.accum <= accum_mode;
                        run_cnt      <= '0;
                        state_q      <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    nsteps_q <= span_steps;
                    idx_q    <= '0;
                    sum_q    <= '0;
                    state_q  <= ST_STEP;
                end
                ST_STEP: begin
                    sum_q <= sum_next;
                    idx_q <= idx_q + CNT_W'(1);
                    if (last_step) begin
                        if (mode_q.accum) begin
                            state_q <= ST_ACC_LO;
                        end else begin
                            result_q <= sum_next;
                            done_q   <= 1'b1;
                            state_q  <= ST_IDLE;
                        end
                    end
                end
                ST_ACC_LO: begin
                    sum_q[OP_W-1:0] <= add_sum;
                    if (acc_hi_zero) begin
                        sum_q[ACC_W-1:OP_W] <= hi_inc;
                        result_q <= {hi_inc, add_sum};
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        carry_q <= add_cout;
                        state_q <= ST_ACC_HI;
                    end
                end
                ST_ACC_HI: begin
                    sum_q[ACC_W-1:OP_W] <= add_sum;
                    result_q <= {add_sum, sum_q[OP_W-1:0]};
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;

    // R7: one-cycle completion pulse, never overlapping busy
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: latched job inputs stay put while the job runs
    a_r8_job_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(a_q) && $stable(b_q) && $stable(acc_q)));

    // R5: a zero operand always takes the minimum digit count
    a_r5_zero_min: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP && (a_q == '0 || b_q == '0)) |-> nsteps_q == CNT_W'(MIN_STEPS));

    // R6: a zero upper addend half finishes straight from the low-half cycle
    a_r6_hi_skip: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACC_LO && acc_hi_zero) |=> (done && state_q == ST_IDLE));

    // R4: latency stays within the bounds that the digit count allows
    a_r4_latency_window: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt >= RUN_W'(MIN_STEPS + 1) && run_cnt <= RUN_W'(NDIG + 3)));

    // R1 and R2: plain result matches a full-width reference multiply
    a_r2_plain_product: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q.accum) |-> result == (mode_q.sgn
            ? ACC_W'($signed({{OP_W{a_q[OP_W-1]}}, a_q}) * $signed({{OP_W{b_q[OP_W-1]}}, b_q}))
            : ACC_W'({{OP_W{1'b0}}, a_q} * {{OP_W{1'b0}}, b_q})));

endmodule

// File: tb/eml_longmul_tb.sv
module eml_longmul_tb;

    typedef struct {
        logic [63:0] res;
        int          lat;
        int          start_cyc;
        string       ptag;
        string       ltag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        signed_mode;
    logic        accum_mode;
    logic [31:0] mcand;
    logic [31:0] mplier;
    logic [63:0] addend;
    logic        busy;
    logic        done;
    logic [63:0] result;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    item_t sb[$];
    logic  prev_done = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    eml_longmul u_dut (
        .clk(clk), .rst(rst), .start(start),
        .signed_mode(signed_mode), .accum_mode(accum_mode),
        .mcand(mcand), .mplier(mplier), .addend(addend),
        .busy(busy), .done(done), .result(result)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_steps(logic [31:0] a, logic [31:0] b, logic sg);
        logic [31:0] r;
        if (a == 0 || b == 0) return 2;
        for (int k = 2; k <= 4; k++) begin
            if (sg) r = $unsigned($signed(b) >>> (8 * k - 1));
            else    r = b >> (8 * k);
            if (r == 32'd0 || r == 32'hFFFF_FFFF) return k;
        end
        return 4;
    endfunction

    task automatic drive(logic [31:0] a, logic [31:0] b, logic sg, logic ac,
                         logic [63:0] adv, bit poke_busy);
        item_t it;
        logic [63:0] p;
        while (busy) @(negedge clk);
        if (sg) p = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
        else    p = {32'd0, a} * {32'd0, b};
        if (ac) p = p + adv;
        it.res       = p;
        it.lat       = 1 + exp_steps(a, b, sg) + (ac ? ((adv[63:32] == 0) ? 1 : 2) : 0);
        it.start_cyc = cyc + 1;
        it.ptag      = ac ? "R3" : (sg ? "R2" : "R1");
        it.ltag      = ac ? "R6" : ((a == 0 || b == 0) ? "R5" : "R4");
        if (poke_busy) it.ltag = "R8";
        sb.push_back(it);
        mcand = a; mplier = b; signed_mode = sg; accum_mode = ac; addend = adv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        checks++;
        if (!busy) begin
            errors++;
            $display("FAIL R7: actual busy %0b expected 1", busy);
        end
        if (poke_busy) begin
            // R8: a second launch while busy must change nothing
            mcand = ~a; mplier = 32'h7; signed_mode = ~sg; accum_mode = 1'b1;
            addend = 64'hFFFF_0000_0000_0001;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // monitor: pops the scoreboard when a result appears
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) check_int("R7 done width", int'(done), 0);
            if (done) begin
                check_int("R7 busy at done", int'(busy), 0);
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8: actual unexpected done expected none");
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check64(it.ptag, result, it.res);
                    check_int(it.ltag, cyc - it.start_cyc, it.lat);
                end
            end
            prev_done <= done;
        end
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; signed_mode = 1'b0; accum_mode = 1'b0;
        mcand = '0; mplier = '0; addend = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check_int("R9 busy", int'(busy), 0);
        check_int("R9 done", int'(done), 0);
        check64("R9 result", result, 64'd0);

        // R1 / R4: unsigned digit boundaries
        drive(32'd3, 32'h0000_00FF, 1'b0, 1'b0, 64'd0, 0);
        drive(32'd3, 32'h0000_FFFF, 1'b0, 1'b0, 64'd0, 0);
        drive(32'd3, 32'h0001_0000, 1'b0, 1'b0, 64'd0, 0);
        drive(32'd3, 32'h0100_0000, 1'b0, 1'b0, 64'd0, 0);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 64'd0, 0);
        // R5: zero operands
        drive(32'd0, 32'hDEAD_BEEF, 1'b0, 1'b0, 64'd0, 0);
        drive(32'hDEAD_BEEF, 32'd0, 1'b1, 1'b0, 64'd0, 0);
        // R2 / R4: signed boundaries one bit under each digit edge
        drive(32'hFFFF_FFF9, 32'hFFFF_FFFF, 1'b1, 1'b0, 64'd0, 0);
        drive(32'd1000, 32'h0000_7FFF, 1'b1, 1'b0, 64'd0, 0);
        drive(32'd1000, 32'h0000_8000, 1'b1, 1'b0, 64'd0, 0);
        drive(32'hFFFF_0001, 32'hFF80_0000, 1'b1, 1'b0, 64'd0, 0);
        drive(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b0, 64'd0, 0);
        drive(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 64'd0, 0);
        // R3 / R6: accumulate, both addend-half cases and carry into the high half
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF, 0);
        drive(32'd5, 32'd7, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 0);
        drive(32'hFFFF_FFFE, 32'd3, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        drive(32'd0, 32'd0, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 0);
        // R8: launch attempts while busy
        drive(32'h0102_0304, 32'h1122_3344, 1'b0, 1'b0, 64'd0, 1);
        drive(32'h8765_4321, 32'hFFFF_FF00, 1'b1, 1'b1, 64'hAAAA_0000_5555_FFFF, 1);
        // pseudo-random sweep
        for (int i = 0; i < 60; i++) begin
            logic [31:0] ra, rb;
            logic [63:0] rc;
            lcg = lcg * 32'd1664525 + 32'd1013904223; ra = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            rb = lcg >> (lcg[3:0] * 2);
            if (lcg[4]) rb = ~rb;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            rc = {(lcg[5] ? lcg : 32'd0), lcg ^ 32'h5A5A_A5A5};
            drive(ra, rb, lcg[6], lcg[7], rc, 0);
        end
        repeat (4) @(negedge clk);
        check_int("R8 leftover items", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule